// File: doc/BRIEF.md
# Three-Entry Push-Down Register Stack

This block holds one working register of an 8/16-bit processor (the accumulator or an index register) as a 16-bit, three-deep push-down stack. The visible register is the top entry; the second and bottom entries keep earlier results on chip. Ordinary loads write only the top entry and stores never pop. The stack moves only under three explicit operations: duplicate, swap and rotate.

Two flags qualify the operations. The size flag selects a 16-bit write rather than an 8-bit one. The indirection flag selects an alternative form of an operation. The parameter `ACC_VARIANT` picks one of two builds:
- The accumulator build (1) reuses the stack operations for a byte swap, a right nibble rotate, and transfers to, from and between the top entry and an external instruction pointer register.
- The pointer build (0) turns the top entry into an up/down counter so that it can act as a stack pointer.

Each clock the decoder reduces the strobes to one named operation:
- HOLD: no change.
- LOAD: write the top entry.
- DUP, SWP, ROT: the three stack moves.
- BSWAP, NROT: the byte swap and the nibble rotate.
- TAI: top entry to pointer register.
- TIA: pointer register to top entry.
- XAI: exchange the two.
- PUSH, POP: count the top entry down or up.

A single register stage then applies that operation. Every operation completes in one cycle.

Top module: `regstk3`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears tos, nos and bos to 0000h.
- R2: A plain duplicate makes (tos, nos, bos) equal to the old (tos, tos, nos).
- R3: A plain swap exchanges tos and nos and leaves bos unchanged.
- R4: A plain rotate makes (tos, nos, bos) equal to the old (nos, bos, tos).
- R5: A load writes only tos. With no strobe active, all three entries hold their values.
- R6: When wide is 0, a loaded value has bits 15:8 forced to zero. When wide is 1, all 16 bits are written.
- R7: Priority is dup_op, then swp_op, then rot_op, then push_op, then pop_op, then ld_en. Only the winning action takes effect.
- R8: In the accumulator build, a swap with indir set replaces tos with {tos[7:0], tos[15:8]}. nos and bos are unchanged.
- R9: In the accumulator build, a rotate with indir set replaces tos with {tos[3:0], tos[15:4]}. nos and bos are unchanged.
- R10: In the accumulator build, a duplicate behaves as follows, and the stack is otherwise unchanged in each case:
  - indir only: ip_wr is 1 in that cycle, ip_dout is tos, and the stack is unchanged.
  - wide only: tos takes ip_in.
  - both flags: tos takes ip_in while ip_wr is 1 with ip_dout equal to the old tos.
- R11: In the pointer build, push_op decrements tos and pop_op increments it. With wide 0 the count wraps within bits 7:0 and bits 15:8 are forced to zero. With wide 1 it wraps modulo 65536.
- R12: The accumulator build ignores push_op and pop_op. The pointer build ignores indir and wide on the stack operations and never asserts ip_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write ld_data into tos |
| ld_data | input | 16 | Value to load |
| dup_op | input | 1 | Duplicate strobe |
| swp_op | input | 1 | Swap strobe |
| rot_op | input | 1 | Rotate strobe |
| wide | input | 1 | Size flag: 16-bit operation |
| indir | input | 1 | Indirection flag: alternative form |
| push_op | input | 1 | Counter push (decrement), pointer build |
| pop_op | input | 1 | Counter pop (increment), pointer build |
| ip_in | input | 16 | Current instruction pointer value |
| ip_wr | output | 1 | Write ip_dout into the pointer register |
| ip_dout | output | 16 | Value for the pointer register (current tos) |
| tos | output | 16 | Top entry |
| nos | output | 16 | Second entry |
| bos | output | 16 | Bottom entry |

## Verification
The bench builds two instances side by side from the same stimulus:
- One with `ACC_VARIANT` = 1.
- One with `ACC_VARIANT` = 0.

Both instances use the default 16-bit width. The accumulator instance brings the byte swap, the nibble rotate and the three pointer transfers within reach. The pointer instance exercises the counter wrap in both widths and confirms that the flags and ip_wr stay inert in that build. Driving both with identical strobes and flags makes the differences between variants, including push/pop being ignored in one build and acted on in the other, visible in the same cycle.

// File: rtl/regstk3_pkg.sv
package regstk3_pkg;

    typedef enum logic [3:0] {
        OP_HOLD,
        OP_LOAD,
        OP_DUP,
        OP_SWP,
        OP_ROT,
        OP_BSWAP,
        OP_NROT,
        OP_TAI,
        OP_TIA,
        OP_XAI,
        OP_PUSH,
        OP_POP
    } stk_op_e;

endpackage

// File: rtl/regstk3_decode.sv
module regstk3_decode
    import regstk3_pkg::*;
#(
    parameter int ACC_VARIANT = 1
) (
    input  logic    dup_op,
    input  logic    swp_op,
    input  logic    rot_op,
    input  logic    ld_en,
    input  logic    push_op,
    input  logic    pop_op,
    input  logic    wide,
    input  logic    indir,
    output stk_op_e op
);
    localparam bit IS_ACC = (ACC_VARIANT != 0);

    // R7: fixed priority dup > swp > rot > push > pop > load
    always_comb begin
        op = OP_HOLD;
        if (dup_op) begin
            if (IS_ACC && indir && wide)  op = OP_XAI;
            else if (IS_ACC && indir)     op = OP_TAI;
            else if (IS_ACC && wide)      op = OP_TIA;
            else                          op = OP_DUP;
        end else if (swp_op) begin
            op = (IS_ACC && indir) ? OP_BSWAP : OP_SWP;
        end else if (rot_op) begin
            op = (IS_ACC && indir) ? OP_NROT : OP_ROT;
        end else if (!IS_ACC && push_op) begin
            op = OP_PUSH;
        end else if (!IS_ACC && pop_op) begin
            op = OP_POP;
        end else if (ld_en) begin
            op = OP_LOAD;
        end
    end

endmodule

// File: rtl/regstk3_step.sv
module regstk3_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] val,
    input  logic             down,
    input  logic             wide,
    output logic [WIDTH-1:0] res
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] full_r;
    logic [HALF-1:0]  low_r;

    always_comb begin
        full_r = down ? (val - 1'b1) : (val + 1'b1);
        low_r  = down ? (val[HALF-1:0] - 1'b1) : (val[HALF-1:0] + 1'b1);
        res    = wide ? full_r : {{(WIDTH-HALF){1'b0}}, low_r};
    end

endmodule

// File: rtl/regstk3_next.sv
module regstk3_next
    import regstk3_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  stk_op_e          op,
    input  logic             wide,
    input  logic [WIDTH-1:0] tos_q,
    input  logic [WIDTH-1:0] nos_q,
    input  logic [WIDTH-1:0] bos_q,
    input  logic [WIDTH-1:0] ld_data,
    input  logic [WIDTH-1:0] ip_in,
    input  logic [WIDTH-1:0] inc_v,
    input  logic [WIDTH-1:0] dec_v,
    output logic [WIDTH-1:0] tos_d,
    output logic [WIDTH-1:0] nos_d,
    output logic [WIDTH-1:0] bos_d,
    output logic             ip_wr,
    output logic [WIDTH-1:0] ip_dout
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] ld_sized;

    always_comb begin
        ld_sized = wide ? ld_data : {{(WIDTH-HALF){1'b0}}, ld_data[HALF-1:0]};
    end

    always_comb begin
        tos_d   = tos_q;
        nos_d   = nos_q;
        bos_d   = bos_q;
        ip_wr   = 1'b0;
        ip_dout = tos_q;
        unique case (op)
            OP_HOLD:  ;
            OP_LOAD:  tos_d = ld_sized;
            OP_DUP:   begin nos_d = tos_q; bos_d = nos_q; end
            OP_SWP:   begin tos_d = nos_q; nos_d = tos_q; end
            OP_ROT:   begin tos_d = nos_q; nos_d = bos_q; bos_d = tos_q; end
            OP_BSWAP: tos_d = {tos_q[HALF-1:0], tos_q[WIDTH-1:HALF]};
            OP_NROT:  tos_d = {tos_q[3:0], tos_q[WIDTH-1:4]};
            OP_TAI:   ip_wr = 1'b1;
            OP_TIA:   tos_d = ip_in;
            OP_XAI:   begin tos_d = ip_in; ip_wr = 1'b1; end
            OP_PUSH:  tos_d = dec_v;
            OP_POP:   tos_d = inc_v;
            default:  ;
        endcase
    end

endmodule

// File: rtl/regstk3.sv
module regstk3
    import regstk3_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int ACC_VARIANT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [WIDTH-1:0] ld_data,
    input  logic             dup_op,
    input  logic             swp_op,
    input  logic             rot_op,
    input  logic             wide,
    input  logic             indir,
    input  logic             push_op,
    input  logic             pop_op,
    input  logic [WIDTH-1:0] ip_in,
    output logic             ip_wr,
    output logic [WIDTH-1:0] ip_dout,
    output logic [WIDTH-1:0] tos,
    output logic [WIDTH-1:0] nos,
    output logic [WIDTH-1:0] bos
);
    localparam bit IS_ACC = (ACC_VARIANT != 0);

    stk_op_e          op;
    logic [WIDTH-1:0] tos_q, nos_q, bos_q;
    logic [WIDTH-1:0] tos_d, nos_d, bos_d;
    logic [WIDTH-1:0] inc_v, dec_v;

    regstk3_decode #(.ACC_VARIANT(ACC_VARIANT)) u_dec (
        .dup_op (dup_op),
        .swp_op (swp_op),
        .rot_op (rot_op),
        .ld_en  (ld_en),
        .push_op(push_op),
        .pop_op (pop_op),
        .wide   (wide),
        .indir  (indir),
        .op     (op)
    );

    generate
        if (IS_ACC) begin : g_acc
            assign inc_v = tos_q;
            assign dec_v = tos_q;
        end else begin : g_ptr
            regstk3_step #(.WIDTH(WIDTH)) u_up (
                .val(tos_q), .down(1'b0), .wide(wide), .res(inc_v)
            );
            regstk3_step #(.WIDTH(WIDTH)) u_dn (
                .val(tos_q), .down(1'b1), .wide(wide), .res(dec_v)
            );
        end
    endgenerate

    regstk3_next #(.WIDTH(WIDTH)) u_next (
        .op     (op),
        .wide   (wide),
        .tos_q  (tos_q),
        .nos_q  (nos_q),
        .bos_q  (bos_q),
        .ld_data(ld_data),
        .ip_in  (ip_in),
        .inc_v  (inc_v),
        .dec_v  (dec_v),
        .tos_d  (tos_d),
        .nos_d  (nos_d),
        .bos_d  (bos_d),
        .ip_wr  (ip_wr),
        .ip_dout(ip_dout)
    );

    // R1: asynchronous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tos_q <= '0;
            nos_q <= '0;
            bos_q <= '0;
        end else begin
            tos_q <= tos_d;
            nos_q <= nos_d;
            bos_q <= bos_d;
        end
    end

    assign tos = tos_q;
    assign nos = nos_q;
    assign bos = bos_q;

endmodule

// File: rtl/regstk3_chk.sv
module regstk3_chk #(
    parameter int WIDTH       = 16,
    parameter int ACC_VARIANT = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_en,
    input logic             dup_op,
    input logic             swp_op,
    input logic             rot_op,
    input logic             wide,
    input logic             indir,
    input logic             push_op,
    input logic             pop_op,
    input logic             ip_wr,
    input logic [WIDTH-1:0] tos,
    input logic [WIDTH-1:0] nos,
    input logic [WIDTH-1:0] bos
);
    localparam bit IS_ACC = (ACC_VARIANT != 0);
    localparam int HALF   = WIDTH / 2;

    logic plain_dup, plain_sr, cnt_act, any_op;
    assign plain_dup = !IS_ACC || (!indir && !wide);
    assign plain_sr  = !IS_ACC || !indir;
    assign cnt_act   = !IS_ACC && (push_op || pop_op);
    assign any_op    = dup_op || swp_op || rot_op || cnt_act;

    a_r2_dup: assert property (@(posedge clk) disable iff (!rst_n)
        dup_op && plain_dup |=> tos == $past(tos) && nos == $past(tos) && bos == $past(nos));

    a_r3_swap: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_op && swp_op && plain_sr |=> tos == $past(nos) && nos == $past(tos) && bos == $past(bos));

    a_r4_rot: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_op && !swp_op && rot_op && plain_sr |=> tos == $past(nos) && nos == $past(bos) && bos == $past(tos));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !any_op && !ld_en |=> $stable(tos) && $stable(nos) && $stable(bos));

    a_r6_narrow_load: assert property (@(posedge clk) disable iff (!rst_n)
        !any_op && ld_en && !wide |=> tos[WIDTH-1:HALF] == '0 && $stable(nos) && $stable(bos));

    a_r12_ipwr_src: assert property (@(posedge clk) disable iff (!rst_n)
        ip_wr |-> IS_ACC && dup_op && indir);

endmodule

bind regstk3 regstk3_chk #(.WIDTH(WIDTH), .ACC_VARIANT(ACC_VARIANT)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .dup_op(dup_op), .swp_op(swp_op),
    .rot_op(rot_op), .wide(wide), .indir(indir), .push_op(push_op), .pop_op(pop_op),
    .ip_wr(ip_wr), .tos(tos), .nos(nos), .bos(bos)
);

// File: tb/test_regstk3.sv
module test_regstk3;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        ld_en = 0, dup_op = 0, swp_op = 0, rot_op = 0;
    logic        wide = 0, indir = 0, push_op = 0, pop_op = 0;
    logic [15:0] ld_data = '0, ip_in = '0;

    logic        ipw_a, ipw_p;
    logic [15:0] ipd_a, ipd_p;
    logic [15:0] tos_a, nos_a, bos_a, tos_p, nos_p, bos_p;

    regstk3 #(.WIDTH(16), .ACC_VARIANT(1)) i_regstk3 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data), .dup_op(dup_op),
        .swp_op(swp_op), .rot_op(rot_op), .wide(wide), .indir(indir), .push_op(push_op),
        .pop_op(pop_op), .ip_in(ip_in), .ip_wr(ipw_a), .ip_dout(ipd_a),
        .tos(tos_a), .nos(nos_a), .bos(bos_a)
    );

    regstk3 #(.WIDTH(16), .ACC_VARIANT(0)) i_regstk3_ptr (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data), .dup_op(dup_op),
        .swp_op(swp_op), .rot_op(rot_op), .wide(wide), .indir(indir), .push_op(push_op),
        .pop_op(pop_op), .ip_in(ip_in), .ip_wr(ipw_p), .ip_dout(ipd_p),
        .tos(tos_p), .nos(nos_p), .bos(bos_p)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [2:0][15:0] ma, mp;

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural reference: entry 0 = top, 1 = second, 2 = bottom
    function automatic logic [2:0][15:0] model(bit acc, logic [2:0][15:0] s,
                                               output string tag, output bit ipw);
        logic [2:0][15:0] r = s;
        int nstrobe = int'(dup_op) + int'(swp_op) + int'(rot_op) + int'(ld_en);
        ipw = 0;
        tag = "R5";
        if (dup_op) begin
            if (acc && indir) begin ipw = 1; tag = "R10"; end
            if (acc && wide) begin r[0] = ip_in; tag = "R10"; end
            if (!(acc && (indir || wide))) begin
                r[1] = s[0]; r[2] = s[1]; tag = (!acc && (indir || wide)) ? "R12" : "R2";
            end
        end else if (swp_op) begin
            if (acc && indir) begin r[0] = {s[0][7:0], s[0][15:8]}; tag = "R8"; end
            else begin r[0] = s[1]; r[1] = s[0]; tag = indir ? "R12" : "R3"; end
        end else if (rot_op) begin
            if (acc && indir) begin r[0] = {s[0][3:0], s[0][15:4]}; tag = "R9"; end
            else begin r[0] = s[1]; r[1] = s[2]; r[2] = s[0]; tag = indir ? "R12" : "R4"; end
        end else if (!acc && push_op) begin
            r[0] = wide ? s[0] - 16'd1 : {8'h00, s[0][7:0] - 8'd1}; tag = "R11";
        end else if (!acc && pop_op) begin
            r[0] = wide ? s[0] + 16'd1 : {8'h00, s[0][7:0] + 8'd1}; tag = "R11";
        end else if (ld_en) begin
            r[0] = wide ? ld_data : {8'h00, ld_data[7:0]}; tag = "R6";
            if (acc && (push_op || pop_op)) tag = "R12";
        end else if (acc && (push_op || pop_op)) begin
            tag = "R12";
        end
        if (nstrobe > 1 || (!acc && (push_op || pop_op) && nstrobe > 0)) tag = "R7";
        return r;
    endfunction

    task automatic cyc(bit d, bit s, bit r, bit l, bit pu, bit po, bit ind, bit wd,
                       logic [15:0] ld, logic [15:0] ip);
        logic [2:0][15:0] ea, ep;
        string ta, tp;
        bit iwa, iwp;
        @(negedge clk);
        dup_op = d; swp_op = s; rot_op = r; ld_en = l; push_op = pu; pop_op = po;
        indir = ind; wide = wd; ld_data = ld; ip_in = ip;
        ea = model(1, ma, ta, iwa);
        ep = model(0, mp, tp, iwp);
        #1;
        chk(ta, "acc ip_wr", {15'd0, ipw_a}, {15'd0, iwa});
        if (iwa) chk(ta, "acc ip_dout", ipd_a, ma[0]);
        chk("R12", "ptr ip_wr", {15'd0, ipw_p}, 16'd0);
        @(posedge clk); #1;
        chk(ta, "acc tos", tos_a, ea[0]);
        chk(ta, "acc nos", nos_a, ea[1]);
        chk(ta, "acc bos", bos_a, ea[2]);
        chk(tp, "ptr tos", tos_p, ep[0]);
        chk(tp, "ptr nos", nos_p, ep[1]);
        chk(tp, "ptr bos", bos_p, ep[2]);
        ma = ea; mp = ep;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        ma = '0; mp = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: cleared during reset
        chk("R1", "acc tos", tos_a, 16'h0); chk("R1", "acc nos", nos_a, 16'h0);
        chk("R1", "acc bos", bos_a, 16'h0); chk("R1", "ptr tos", tos_p, 16'h0);
        chk("R1", "ptr nos", nos_p, 16'h0); chk("R1", "ptr bos", bos_p, 16'h0);
        @(negedge clk); rst_n = 1'b1;

        // directed: d s r l pu po ind wd ld ip
        cyc(0,0,0,1,0,0,0,0,16'h12AB,16'h0);   // R6 narrow load
        cyc(0,0,0,1,0,0,0,1,16'hBEEF,16'h0);   // R6 wide load
        cyc(1,0,0,0,0,0,0,0,16'h0,16'h0);      // R2
        cyc(0,0,0,1,0,0,0,1,16'h1234,16'h0);   // R5 only tos
        cyc(0,1,0,0,0,0,0,0,16'h0,16'h0);      // R3
        cyc(0,0,1,0,0,0,0,0,16'h0,16'h0);      // R4
        cyc(0,0,0,0,0,0,0,0,16'h0,16'h0);      // R5 hold
        cyc(0,1,0,0,0,0,1,0,16'h0,16'h0);      // R8
        cyc(0,0,1,0,0,0,1,0,16'h0,16'h0);      // R9
        cyc(1,0,0,0,0,0,1,0,16'h0,16'h5A5A);   // R10 TAI
        cyc(1,0,0,0,0,0,0,1,16'h0,16'hC0DE);   // R10 TIA
        cyc(1,0,0,0,0,0,1,1,16'h0,16'h7777);   // R10 XAI
        cyc(0,0,0,1,0,0,0,1,16'h0000,16'h0);
        cyc(0,0,0,0,1,0,0,0,16'h0,16'h0);      // R11 narrow wrap to 00FF
        cyc(0,0,0,0,0,1,0,0,16'h0,16'h0);      // R11 back to 0000
        cyc(0,0,0,0,1,0,0,1,16'h0,16'h0);      // R11 wide wrap to FFFF
        cyc(0,0,0,0,0,1,0,1,16'h0,16'h0);
        cyc(1,1,1,1,1,1,0,0,16'h4444,16'h0);   // R7 all at once
        cyc(0,0,0,1,1,0,0,1,16'h9999,16'h0);   // R7 push beats load / R12
        cyc(0,0,0,0,1,1,0,1,16'h0,16'h0);      // R7 push beats pop

        for (int i = 0; i < 600; i++) begin
            logic [31:0] rv = $urandom;
            cyc(rv[2:0] == 0, rv[5:3] == 0, rv[8:6] == 0, rv[10:9] != 0,
                rv[13:11] == 0, rv[16:14] == 0, rv[17], rv[18],
                16'($urandom), 16'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule